// File: doc/BRIEF.md
# 32-bit Normalize and Barrel Shift Unit

This unit transforms a 32-bit operand held in a shared data register. It either normalizes the operand, shifting it left until its top bit is set and reporting how many places it moved, or shifts it by a programmed amount. A shift can be logical, circular within 32 bits, or circular through an extra carry flag, which makes a 33-bit ring. The host loads the operand with four byte writes, least significant byte first. It then writes a control byte, and that write starts the operation. The host polls the busy flag and reads the result back most significant byte first.

The register file has three selectors on a byte-wide port: data (0), control (1) and flags (2). Selector 3 reads as zero and ignores writes. The sequencing is done by a small state machine:
- IDLE: waits for the start write. A control write with a zero count field takes the IDLE→NORM transition; a nonzero count takes IDLE→SHIFT.
- NORM: tests the top bit each cycle. It takes NORM→NORM while a shift is still needed, and NORM→DONE once bit 31 is set or the operand is zero.
- SHIFT: performs one step per cycle. It takes SHIFT→SHIFT until the last step, then SHIFT→DONE.
- DONE: lasts one cycle. It records the normalize count, rewinds both byte pointers and takes DONE→IDLE.

Top module: `nbs_unit`

## Requirements
- R1: Successive writes to selector 0 fill data bits 7:0, 15:8, 23:16 and 31:24 in turn; the write pointer starts at the low byte after reset and after every completed operation, and wraps after four writes.
- R2: Successive reads of selector 0 (rd_en high) return bits 31:24, 23:16, 15:8 and 7:0 in turn; the read pointer restarts at the top byte after reset and after every completed operation.
- R3: The control byte is encoded as follows: bit 7 selects direction (0 left, 1 right), bit 6 selects circular mode, bit 5 makes the carry flag part of the shift, and bits 4:0 hold the count. Writing it while idle with a nonzero count shifts the data by that many places. After a shift, the control byte reads back as written.
- R4: A non-circular shift fills vacated bits with 0. A circular shift without the carry rotates the 32 bits. When bit 5 is 0, the carry flag is unchanged.
- R5: The carry flag is bit 5 of selector 2 and is writable while idle. With carry included, a circular shift rotates the 33-bit ring {carry, data}, and a non-circular shift leaves the last bit shifted out in the carry. For example, carry 1 with 0x91A2B380, rotated right by 7, gives 0x03234567 and carry 0.
- R6: A control write with count 0 normalizes: the data shifts left until bit 31 is 1, and bits 4:0 of the control byte then report the number of shifts; 0x01234567 gives 0x91A2B380 and 7. The carry flag is unchanged.
- R7: Normalizing an all-zero operand leaves it zero and reports a count of 0.
- R8: busy and flag bit 7 are high from the cycle after the start write. A shift by n keeps them high for exactly n+1 cycles; a normalize that needs k shifts keeps them high for k+2 cycles; neither exceeds 36 cycles.
- R9: Writes to any selector while busy are ignored: the result, the carry and the byte pointers are the same as without them.
- R10: After reset, data, control byte and carry are zero and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write selector: 0 data, 1 control, 2 flags |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; advances the data read pointer |
| rd_sel | input | 2 | Read selector |
| rd_data | output | 8 | Read byte, combinational from rd_sel |
| busy | output | 1 | Operation in progress |

## Verification
A result becomes due only when busy falls. A shift by n is due n+1 cycles after the clock edge that takes the control write, and a normalize needing k shifts is due k+2 cycles after it. The bench drives each write for one edge and then counts the falling edges on which busy is high, comparing that count with the exact figure from R8. It reads data, carry and control only after it has seen busy low. Read data is sampled one time step after the selector settles, before the edge that advances the pointer.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int NBYTES = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_NORM  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } nbs_state_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } nbs_sel_e;

    typedef struct packed {
        logic             dir_right;
        logic             circ;
        logic             use_carry;
        logic [CNT_W-1:0] count;
    } nbs_ctrl_t;
endpackage

// File: rtl/nbs_step.sv
module nbs_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    input  logic         dir_right,
    input  logic         circ,
    input  logic         use_carry,
    output logic [W-1:0] a_o,
    output logic         c_o
);
    logic fill_r, fill_l, out_bit;

    always_comb begin
        fill_r  = circ ? (use_carry ? c_i : a_i[0])   : 1'b0;
        fill_l  = circ ? (use_carry ? c_i : a_i[W-1]) : 1'b0;
        out_bit = dir_right ? a_i[0] : a_i[W-1];
        a_o     = dir_right ? {fill_r, a_i[W-1:1]} : {a_i[W-2:0], fill_l};
        c_o     = use_carry ? out_bit : c_i;
    end
endmodule

// File: rtl/nbs_ptr.sv
module nbs_ptr #(
    parameter int N = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr <= '0;
        else if (clr)    ptr <= '0;
        else if (inc)    ptr <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm
    import nbs_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int MAX_BUSY = 36,
    localparam int BW = $clog2(MAX_BUSY + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] shift_count,
    input  logic          data_msb,
    input  logic          data_zero,
    output nbs_state_e    state_o,
    output logic          step_o,
    output logic          done_o,
    output logic          busy_o,
    output logic [CW-1:0] norm_count_o
);
    nbs_state_e    state_q, state_d;
    logic [CW-1:0] remain_q;
    logic [CW-1:0] nshift_q;
    logic          norm_stop;

    assign norm_stop = data_msb | data_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (shift_count == '0) ? ST_NORM : ST_SHIFT;
            ST_NORM:  if (norm_stop) state_d = ST_DONE;
            ST_SHIFT: if (remain_q == CW'(1)) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            nshift_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            remain_q <= shift_count;
            nshift_q <= '0;
        end else if (state_q == ST_SHIFT) begin
            remain_q <= remain_q - 1'b1;
        end else if (state_q == ST_NORM && !norm_stop) begin
            nshift_q <= nshift_q + 1'b1;
        end
    end

    always_comb begin
        step_o = 1'b0;
        done_o = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_NORM:  step_o = !norm_stop;
            ST_SHIFT: step_o = 1'b1;
            ST_DONE:  done_o = 1'b1;
        endcase
    end

    assign state_o      = state_q;
    assign norm_count_o = nshift_q;

    logic [BW-1:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            busy_len_q <= '0;
        else if (!busy_o)      busy_len_q <= '0;
        else if (busy_len_q != '1) busy_len_q <= busy_len_q + 1'b1;
    end

    a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len_q <= BW'(MAX_BUSY))
        else $error("busy held longer than limit");

    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> !busy_o)
        else $error("busy not released after completion");
endmodule

// File: rtl/nbs_unit.sv
module nbs_unit
    import nbs_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W,
    localparam int NB = W / BW,
    localparam int CW = $clog2(W),
    localparam int PW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [BW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [1:0]    rd_sel,
    output logic [BW-1:0] rd_data,
    output logic          busy
);
    localparam int CARRY_BIT = 5;
    localparam int BUSY_BIT  = 7;

    logic [W-1:0]  data_q;
    logic          carry_q;
    nbs_ctrl_t     ctrl_q;

    nbs_state_e    state;
    logic          step, done;
    logic [CW-1:0] norm_count;
    logic [PW-1:0] wptr, rptr;

    logic wr_data_hit, wr_ctrl_hit, wr_flag_hit, rd_data_hit;

    assign wr_data_hit = wr_en && !busy && (nbs_sel_e'(wr_sel) == SEL_DATA);
    assign wr_ctrl_hit = wr_en && !busy && (nbs_sel_e'(wr_sel) == SEL_CTRL);
    assign wr_flag_hit = wr_en && !busy && (nbs_sel_e'(wr_sel) == SEL_FLAG);
    assign rd_data_hit = rd_en && !busy && (nbs_sel_e'(rd_sel) == SEL_DATA);

    nbs_fsm #(.CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (wr_ctrl_hit),
        .shift_count  (wr_data[CW-1:0]),
        .data_msb     (data_q[W-1]),
        .data_zero    (data_q == '0),
        .state_o      (state),
        .step_o       (step),
        .done_o       (done),
        .busy_o       (busy),
        .norm_count_o (norm_count)
    );

    nbs_ptr #(.N(NB)) u_wptr (
        .clk (clk), .rst_n (rst_n), .clr (done), .inc (wr_data_hit), .ptr (wptr)
    );

    nbs_ptr #(.N(NB)) u_rptr (
        .clk (clk), .rst_n (rst_n), .clr (done), .inc (rd_data_hit), .ptr (rptr)
    );

    logic          in_norm;
    logic          st_right, st_circ, st_carry;
    logic [W-1:0]  next_a;
    logic          next_c;

    assign in_norm  = (state == ST_NORM);
    assign st_right = in_norm ? 1'b0 : ctrl_q.dir_right;
    assign st_circ  = in_norm ? 1'b0 : ctrl_q.circ;
    assign st_carry = in_norm ? 1'b0 : ctrl_q.use_carry;

    nbs_step #(.W(W)) u_step (
        .a_i       (data_q),
        .c_i       (carry_q),
        .dir_right (st_right),
        .circ      (st_circ),
        .use_carry (st_carry),
        .a_o       (next_a),
        .c_o       (next_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            carry_q <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            if (step) begin
                data_q  <= next_a;
                carry_q <= next_c;
            end else begin
                if (wr_data_hit) data_q[wptr*BW +: BW] <= wr_data;
                if (wr_flag_hit) carry_q <= wr_data[CARRY_BIT];
            end
            if (wr_ctrl_hit)
                ctrl_q <= nbs_ctrl_t'(wr_data);
            else if (done && ctrl_q.count == '0)
                ctrl_q.count <= norm_count;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (nbs_sel_e'(rd_sel))
            SEL_DATA: rd_data = data_q[(NB - 1 - int'(rptr))*BW +: BW];
            SEL_CTRL: rd_data = ctrl_q;
            SEL_FLAG: begin
                rd_data[BUSY_BIT]  = busy;
                rd_data[CARRY_BIT] = carry_q;
            end
            SEL_NONE: rd_data = '0;
        endcase
    end

    a_r9_data_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(wr_en && wr_sel == 2'd0)) |=> $stable(data_q))
        else $error("data changed without a write or an operation");

    a_r4_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !ctrl_q.use_carry) |=> $stable(carry_q))
        else $error("carry changed while excluded from shift");

    a_r6_norm_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM) |=> $stable(carry_q))
        else $error("carry changed during normalize");

    a_r6_norm_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && ctrl_q.count == '0) |-> (data_q[W-1] || data_q == '0))
        else $error("normalize finished with top bit clear");

    a_r9_ctrl_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_DONE) |=> $stable(ctrl_q))
        else $error("control byte changed while busy");
endmodule

// File: tb/nbs_unit_tb.sv
`timescale 1ns/1ps
module nbs_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    nbs_unit u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .rd_en (rd_en), .rd_sel (rd_sel),
        .rd_data (rd_data), .busy (busy)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = s;
        #1 v = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] a);
        for (int i = 0; i < 4; i++) wr(2'd0, a[i*8 +: 8]);
    endtask

    task automatic read_data(output logic [31:0] a);
        logic [7:0] b;
        for (int i = 3; i >= 0; i--) begin
            rd(2'd0, b);
            a[i*8 +: 8] = b;
        end
    endtask

    task automatic wait_idle(output int len);
        len = 0;
        @(negedge clk);
        while (busy && len < 60) begin
            len++;
            @(negedge clk);
        end
    endtask

    function automatic logic [32:0] ref_shift(input logic [31:0] a, input logic c,
                                              input logic [7:0] ctl);
        int n = int'(ctl[4:0]);
        logic [65:0] x, y;
        logic [31:0] r;
        logic co;
        co = c;
        if (ctl[6] && ctl[5]) begin
            x = {33'd0, c, a};
            if (ctl[7]) y = (x >> n) | (x << (33 - n));
            else        y = (x << n) | (x >> (33 - n));
            r  = y[31:0];
            co = y[32];
        end else if (ctl[6]) begin
            if (ctl[7]) r = (a >> n) | (a << (32 - n));
            else        r = (a << n) | (a >> (32 - n));
        end else begin
            if (ctl[7]) begin r = a >> n; if (ctl[5]) co = a[n-1];  end
            else        begin r = a << n; if (ctl[5]) co = a[32-n]; end
        end
        return {co, r};
    endfunction

    task automatic run_shift(input logic [31:0] a, input logic c, input logic [7:0] ctl);
        logic [32:0] e;
        logic [31:0] got;
        logic [7:0]  f, cr;
        int len;
        wr(2'd2, {2'b00, c, 5'd0});
        load(a);
        wr(2'd1, ctl);
        wait_idle(len);
        e = ref_shift(a, c, ctl);
        check("R8 shift busy length", 64'(len), 64'(int'(ctl[4:0]) + 1));
        read_data(got);
        check(ctl[5] ? "R5 carry shift data" : "R4 shift data", 64'(got), 64'(e[31:0]));
        rd(2'd2, f);
        check(ctl[5] ? "R5 carry out" : "R4 carry unchanged", 64'(f[5]), 64'(e[32]));
        check("R8 busy flag low", 64'(f[7]), 64'd0);
        rd(2'd1, cr);
        check("R3 control readback", 64'(cr), 64'(ctl));
    endtask

    task automatic run_norm(input logic [31:0] a, input logic c);
        int k;
        logic [31:0] got, e;
        logic [7:0]  cr, f;
        int len;
        k = 0;
        e = a;
        if (a != 0) while (!e[31]) begin e = e << 1; k++; end
        wr(2'd2, {2'b00, c, 5'd0});
        load(a);
        wr(2'd1, 8'h00);
        wait_idle(len);
        check("R8 normalize busy length", 64'(len), 64'(k + 2));
        read_data(got);
        check(a == 0 ? "R7 zero normalize data" : "R6 normalize data", 64'(got), 64'(e));
        rd(2'd1, cr);
        check(a == 0 ? "R7 zero normalize count" : "R6 normalize count", 64'(cr[4:0]), 64'(k));
        rd(2'd2, f);
        check("R6 normalize carry kept", 64'(f[5]), 64'(c));
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [31:0] got;
        logic [31:0] pats [4];
        int len;
        pats[0] = 32'h91A2B380; pats[1] = 32'h00000001;
        pats[2] = 32'h80000001; pats[3] = 32'hA5C30F96;

        #12 rst_n = 1'b1;

        // R10: reset state
        check("R10 busy after reset", 64'(busy), 64'd0);
        rd(2'd1, v); check("R10 control after reset", 64'(v), 64'd0);
        rd(2'd2, v); check("R10 flags after reset", 64'(v), 64'd0);
        rd(2'd3, v); check("R10 unused selector", 64'(v), 64'd0);
        read_data(got); check("R10 data after reset", 64'(got), 64'd0);

        // R1/R2: byte order without an operation
        wr(2'd0, 8'h11); wr(2'd0, 8'h22); wr(2'd0, 8'h33); wr(2'd0, 8'h44);
        rd(2'd0, v); check("R2 first read is top byte", 64'(v), 64'h44);
        rd(2'd0, v); check("R2 second read", 64'(v), 64'h33);
        rd(2'd0, v); check("R1 third read", 64'(v), 64'h22);
        rd(2'd0, v); check("R1 fourth read is low byte", 64'(v), 64'h11);

        // R6 and R5 worked examples
        run_norm(32'h01234567, 1'b0);
        wr(2'd2, 8'h20);
        load(32'h91A2B380);
        wr(2'd1, 8'hE7);
        wait_idle(len);
        read_data(got);
        check("R5 33-bit rotate example", 64'(got), 64'h03234567);
        rd(2'd2, v); check("R5 example carry out", 64'(v[5]), 64'd0);

        // R7 zero operand
        run_norm(32'h0, 1'b1);

        // R6 normalize sweep over every top-bit position
        for (int i = 0; i < 32; i++) begin
            logic [31:0] one;
            one = 32'h1 << i;
            run_norm(one | ((one - 1) & 32'h2468ACE1), i[0]);
        end

        // R9: writes while busy are ignored
        wr(2'd2, 8'h00);
        load(32'h12345678);
        wr(2'd1, 8'h94);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h20);
        wait_idle(len);
        read_data(got);
        check("R9 data unaffected by busy writes", 64'(got), 64'(32'h12345678 >> 20));
        rd(2'd2, v); check("R9 carry unaffected by busy write", 64'(v[5]), 64'd0);
        rd(2'd1, v); check("R9 control unaffected by busy write", 64'(v), 64'h94);

        // R3/R4/R5: sweep of modes, counts, carry values and patterns
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 8; m++)
                for (int n = 1; n < 32; n++)
                    for (int c = 0; c < 2; c++)
                        run_shift(pats[p], c[0], {m[2:0], n[4:0]});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule